// File: doc/BRIEF.md
# Single-Phase Sine-Triangle Bridge Modulator

This block produces the four switch commands for a single-phase full-bridge inverter. It compares a digitally generated sine reference against a symmetric triangular carrier. A phase accumulator steps through a 64-point sine table, so the phase increment sets the output fundamental frequency. The carrier peak sets the carrier period, and with it the number of switching pulses in each half-cycle. An unsigned gain scales the sine before the comparison. The effective modulation index is the scaled reference amplitude divided by half the carrier span, and it sets the RMS value of the bridge output.

Leg A is driven by comparing the reference against the carrier. Leg B is driven by comparing the phase-opposed (negated) reference against the same carrier. Each leg has an upper gate and a lower gate. Once running, the lower gate is always the complement of the upper gate, so the two switches of one leg are never commanded on together. Dead time must be added downstream. The three control inputs are sampled only at a carrier valley, so a pulse is never cut short by a mid-period change.

Top module: `bridge_spwm`

## Requirements
- R1: While `rst` is high, and for the first clock after it falls, all four gate outputs are low. From the second clock after release the gates follow R5 to R7.
- R2: The carrier counter starts at 0 on reset. It counts up by one per clock to the active peak, then down by one per clock back to 0, giving a period of twice the peak. At every valley (counter at 0) the peak is reloaded from `span_in`, and values below 2 are taken as 2.
- R3: A PW-bit phase accumulator adds the active increment every clock and wraps. Its top 6 bits i select the sine sample round(2047 * sin(2*pi*(i+0.5)/64)). Samples in the second half of the cycle are the negatives of the first half.
- R4: The selected sample s is multiplied by the active gain g, which is unsigned Q1.15 with 15 fraction bits. The result is floor(s*g / 2^15), saturated to the range -2047..+2047, and this is the reference r.
- R5: With carrier count c and active peak P, `leg_a_hi` is high when r*P > (2c - P)*2048.
- R6: `leg_b_hi` is high when -r*P > (2c - P)*2048, using the same c and P as R5.
- R7: Once running, `leg_a_lo` is the complement of `leg_a_hi` and `leg_b_lo` is the complement of `leg_b_hi`. Neither leg ever has both of its gates high.
- R8: `step_in` and `gain_in` are copied into the active increment and active gain only in a valley cycle. `span_in` is likewise copied only at a valley (R2). Between valleys the inputs have no effect.
- R9: Timing. Each clock, in order, the accumulator register is updated, the table sample register is loaded from the accumulator, the reference register is loaded from that sample, and the gates are registered from the current reference, carrier count and peak. A value latched at a valley therefore reaches the gates a few clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | PW | Phase increment per clock (output frequency) |
| span_in | input | CW | Carrier peak count (carrier period is twice this) |
| gain_in | input | AW | Reference gain, unsigned Q1.15 |
| leg_a_hi | output | 1 | Leg A upper switch; with leg B lower forms the first diagonal pair |
| leg_a_lo | output | 1 | Leg A lower switch |
| leg_b_hi | output | 1 | Leg B upper switch; with leg A lower forms the opposite diagonal pair |
| leg_b_lo | output | 1 | Leg B lower switch |

## Verification
The delicate coincidence is the valley cycle. In that cycle new parameters are latched and the carrier turns around on a peak that is changing. In the same cycle the gate comparison still uses the old peak and the count of 0. The bench provokes this by rewriting all three inputs on random clocks, many of which land on a valley, and by switching between very short and long peaks. Its reference model sequences the latch, turnaround and comparison in the order given by R9, and each gate is compared against the model on every clock.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  // Width of the signed sine sample and of the scaled reference.
  localparam int SINE_W  = 12;
  localparam int SINE_MX = (1 << (SINE_W - 1)) - 1;
  // Index bits into the full-cycle table and into one quarter of it.
  localparam int IDX_W   = 6;
  localparam int QIDX_W  = IDX_W - 2;

  // Quarter-wave magnitude, sampled half a step off the axis so that
  // the quarters mirror exactly and no sample sits on zero or the crest.
  function automatic logic [SINE_W-2:0] quarter_mag(input logic [QIDX_W-1:0] j);
    logic [SINE_W-2:0] m;
    case (j)
      4'd0:  m = 11'd100;
      4'd1:  m = 11'd300;
      4'd2:  m = 11'd497;
      4'd3:  m = 11'd690;
      4'd4:  m = 11'd875;
      4'd5:  m = 11'd1052;
      4'd6:  m = 11'd1219;
      4'd7:  m = 11'd1375;
      4'd8:  m = 11'd1517;
      4'd9:  m = 11'd1644;
      4'd10: m = 11'd1756;
      4'd11: m = 11'd1850;
      4'd12: m = 11'd1927;
      4'd13: m = 11'd1986;
      4'd14: m = 11'd2025;
      default: m = 11'd2045;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] span_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] peak_q,
  output logic          valley
);

  localparam logic [CW-1:0] MIN_PEAK = CW'(2);

  logic          up;
  logic [CW-1:0] peak_eff;

  assign valley   = (cnt == '0);
  assign peak_eff = (span_in < MIN_PEAK) ? MIN_PEAK : span_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      up     <= 1'b1;
      peak_q <= MIN_PEAK;
    end else if (valley) begin
      peak_q <= peak_eff;
      cnt    <= CW'(1);
      up     <= 1'b1;
    end else if (up) begin
      cnt <= cnt + CW'(1);
      if (cnt + CW'(1) == peak_q) up <= 1'b0;
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/spwm_reference.sv
module spwm_reference
  import spwm_pkg::*;
#(
  parameter int PW = 16,
  parameter int AW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valley,
  input  logic [PW-1:0]            step_in,
  input  logic [AW-1:0]            gain_in,
  output logic signed [SINE_W-1:0] ref_o,
  output logic [PW-1:0]            inc_q,
  output logic [AW-1:0]            amp_q
);

  localparam int FRAC = AW - 1;
  localparam int PRW  = SINE_W + AW + 1;

  logic [PW-1:0]            acc;
  logic [IDX_W-1:0]         idx;
  logic [QIDX_W-1:0]        qj;
  logic [SINE_W-2:0]        mag;
  logic signed [SINE_W-1:0] smp_r;
  logic signed [PRW-1:0]    prod;
  logic signed [PRW-1:0]    shifted;
  logic signed [SINE_W-1:0] sat;

  assign idx = acc[PW-1 -: IDX_W];
  // Odd quarters run the table backwards.
  assign qj  = idx[QIDX_W] ? ~idx[QIDX_W-1:0] : idx[QIDX_W-1:0];
  assign mag = quarter_mag(qj);

  assign prod    = PRW'(smp_r) * PRW'($signed({1'b0, amp_q}));
  assign shifted = prod >>> FRAC;

  always_comb begin
    if (shifted > PRW'(SINE_MX))       sat = SINE_W'(SINE_MX);
    else if (shifted < -PRW'(SINE_MX)) sat = -SINE_W'(SINE_MX);
    else                               sat = shifted[SINE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      inc_q <= '0;
      amp_q <= '0;
      smp_r <= '0;
      ref_o <= '0;
    end else begin
      if (valley) begin
        inc_q <= step_in;
        amp_q <= gain_in;
      end
      acc   <= acc + inc_q;
      smp_r <= idx[IDX_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
      ref_o <= sat;
    end
  end

endmodule

// File: rtl/spwm_gate.sv
module spwm_gate
  import spwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valley,
  input  logic signed [SINE_W-1:0] ref_i,
  input  logic [CW-1:0]            cnt,
  input  logic [CW-1:0]            peak_q,
  output logic                     a_hi,
  output logic                     a_lo,
  output logic                     b_hi,
  output logic                     b_lo
);

  localparam int CMPW = SINE_W + CW + 2;
  localparam logic signed [CMPW-1:0] HALF_FS = CMPW'(SINE_MX + 1);

  logic                   armed;
  logic signed [CMPW-1:0] ref_x, pk_x, cnt2_x, lhs, rhs;
  logic                   a_on, b_on;

  assign ref_x  = CMPW'(ref_i);
  assign pk_x   = CMPW'({1'b0, peak_q});
  assign cnt2_x = CMPW'({1'b0, cnt, 1'b0});
  assign lhs    = ref_x * pk_x;
  assign rhs    = (cnt2_x - pk_x) * HALF_FS;
  assign a_on   = lhs > rhs;
  assign b_on   = -lhs > rhs;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      a_hi  <= 1'b0;
      a_lo  <= 1'b0;
      b_hi  <= 1'b0;
      b_lo  <= 1'b0;
    end else begin
      if (valley) armed <= 1'b1;
      if (armed) begin
        a_hi <= a_on;
        a_lo <= !a_on;
        b_hi <= b_on;
        b_lo <= !b_on;
      end
    end
  end

endmodule

// File: rtl/bridge_spwm.sv
module bridge_spwm
  import spwm_pkg::*;
#(
  parameter int CW = 12,
  parameter int PW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] step_in,
  input  logic [CW-1:0] span_in,
  input  logic [AW-1:0] gain_in,
  output logic          leg_a_hi,
  output logic          leg_a_lo,
  output logic          leg_b_hi,
  output logic          leg_b_lo
);

  logic [CW-1:0]            car_cnt;
  logic [CW-1:0]            peak_q;
  logic                     valley;
  logic signed [SINE_W-1:0] ref_val;
  logic [PW-1:0]            inc_q;
  logic [AW-1:0]            amp_q;

  spwm_carrier #(.CW(CW)) u_carrier (
    .clk(clk), .rst(rst), .span_in(span_in),
    .cnt(car_cnt), .peak_q(peak_q), .valley(valley)
  );

  spwm_reference #(.PW(PW), .AW(AW)) u_reference (
    .clk(clk), .rst(rst), .valley(valley),
    .step_in(step_in), .gain_in(gain_in),
    .ref_o(ref_val), .inc_q(inc_q), .amp_q(amp_q)
  );

  spwm_gate #(.CW(CW)) u_gate (
    .clk(clk), .rst(rst), .valley(valley), .ref_i(ref_val),
    .cnt(car_cnt), .peak_q(peak_q),
    .a_hi(leg_a_hi), .a_lo(leg_a_lo), .b_hi(leg_b_hi), .b_lo(leg_b_lo)
  );

endmodule

// File: rtl/spwm_chk.sv
module spwm_chk #(
  parameter int CW = 12,
  parameter int PW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          a_hi,
  input logic          a_lo,
  input logic          b_hi,
  input logic          b_lo,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] peak_q,
  input logic [PW-1:0] inc_q,
  input logic [AW-1:0] amp_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(a_hi || a_lo || b_hi || b_lo));

  // R7
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_hi && a_lo));

  // R7
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(b_hi && b_lo));

  // R2
  carrier_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1)));

  // R2
  carrier_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= peak_q);

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> ($stable(peak_q) && $stable(inc_q) && $stable(amp_q)));

endmodule

bind bridge_spwm spwm_chk #(.CW(CW), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .a_hi(leg_a_hi), .a_lo(leg_a_lo), .b_hi(leg_b_hi), .b_lo(leg_b_lo),
  .cnt(car_cnt), .peak_q(peak_q), .inc_q(inc_q), .amp_q(amp_q)
);

// File: tb/bridge_spwm_bench.sv
module bridge_spwm_bench;

  localparam int CW = 12;
  localparam int PW = 16;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] step_in = '0;
  logic [CW-1:0] span_in = '0;
  logic [AW-1:0] gain_in = '0;
  logic          leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_spwm #(.CW(CW), .PW(PW), .AW(AW)) u_bridge_spwm (
    .clk(clk), .rst(rst), .step_in(step_in), .span_in(span_in), .gain_in(gain_in),
    .leg_a_hi(leg_a_hi), .leg_a_lo(leg_a_lo), .leg_b_hi(leg_b_hi), .leg_b_lo(leg_b_lo)
  );

  // Sine sample from R3, computed from the formula.
  function automatic int sine_of(int i);
    real r;
    r = 2047.0 * $sin(2.0 * 3.14159265358979 * (real'(i) + 0.5) / 64.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  // Reference scaling from R4.
  function automatic int scale_ref(int s, int g);
    longint p;
    p = longint'(s) * longint'(g);
    p = p >>> 15;
    if (p > 2047) return 2047;
    if (p < -2047) return -2047;
    return int'(p);
  endfunction

  // Model state, following the register order of R9.
  int m_cnt = 0, m_pk = 2, m_inc = 0, m_amp = 0, m_acc = 0, m_s = 0, m_ref = 0;
  bit m_up = 1'b1, m_armed = 1'b0;
  bit e_ahi = 0, e_alo = 0, e_bhi = 0, e_blo = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_pk = 2; m_inc = 0; m_amp = 0; m_acc = 0; m_s = 0; m_ref = 0;
      m_up = 1'b1; m_armed = 1'b0;
      e_ahi = 0; e_alo = 0; e_bhi = 0; e_blo = 0;
    end else begin
      bit vly;
      longint lhs, rhs;
      vly = (m_cnt == 0);
      if (m_armed) begin
        lhs = longint'(m_ref) * m_pk;
        rhs = longint'(2 * m_cnt - m_pk) * 2048;
        e_ahi = (lhs > rhs);  e_alo = !e_ahi;
        e_bhi = (-lhs > rhs); e_blo = !e_bhi;
      end
      if (vly) m_armed = 1'b1;
      m_ref = scale_ref(m_s, m_amp);
      m_s   = sine_of(m_acc >> (PW - 6));
      m_acc = (m_acc + m_inc) % (1 << PW);
      if (vly) begin
        m_inc = int'(step_in);
        m_amp = int'(gain_in);
        m_pk  = (int'(span_in) < 2) ? 2 : int'(span_in);
        m_cnt = 1;
        m_up  = 1'b1;
      end else if (m_up) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == m_pk) m_up = 1'b0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (!m_armed && (leg_a_hi || leg_a_lo || leg_b_hi || leg_b_lo)) begin
        fails++;
        $display("FAIL R1 gates=%b%b%b%b expected 0000", leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo);
      end else if (leg_a_hi !== e_ahi) begin
        fails++;
        $display("FAIL R5 (R3 R4 R8 R9) leg_a_hi=%b expected %b", leg_a_hi, e_ahi);
      end else if (leg_b_hi !== e_bhi) begin
        fails++;
        $display("FAIL R6 leg_b_hi=%b expected %b", leg_b_hi, e_bhi);
      end else if (leg_a_lo !== e_alo || leg_b_lo !== e_blo) begin
        fails++;
        $display("FAIL R7 lo gates=%b%b expected %b%b", leg_a_lo, leg_b_lo, e_alo, e_blo);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_inputs();
    int r;
    r = int'($urandom % 10);
    if (r == 0) span_in = CW'($urandom % 2);
    else        span_in = CW'(2 + ($urandom % 300));
    step_in = PW'($urandom);
    gain_in = AW'($urandom);
  endtask

  // R2: with zero reference the leg A pulse repeats every 2*peak clocks.
  task automatic check_period(int pk);
    int t, first, second;
    bit prev;
    span_in = CW'(pk); gain_in = '0; step_in = '0;
    run(8 * pk + 10);
    first = -1; second = -1; prev = leg_a_hi; t = 0;
    while (second < 0 && t < 20 * pk) begin
      @(negedge clk);
      t++;
      if (leg_a_hi && !prev) begin
        if (first < 0) first = t; else second = t;
      end
      prev = leg_a_hi;
    end
    vectors++;
    if (second - first != 2 * pk) begin
      fails++;
      $display("FAIL R2 carrier period=%0d expected %0d", second - first, 2 * pk);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    run(4);
    rst = 1'b0;
    // R1: outputs held low for one clock after release
    @(negedge clk);
    vectors++;
    if (leg_a_hi || leg_a_lo || leg_b_hi || leg_b_lo) begin
      fails++;
      $display("FAIL R1 first cycle gates=%b%b%b%b expected 0000",
               leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo);
    end
    // Clamped minimum peak
    span_in = 12'd0; gain_in = 16'h8000; step_in = 16'h0400;
    run(300);
    check_period(10);
    check_period(2);
    // Saturating gain with a slow reference
    span_in = 12'd255; gain_in = 16'hFFFF; step_in = 16'h0100;
    run(2000);
    // R8: inputs stormed on random clocks, many landing on valleys
    for (int seg = 0; seg < 40; seg++) begin
      rand_inputs();
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (($urandom % 8) == 0) rand_inputs();
      end
    end
    // R1: reset in mid-run
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    for (int seg = 0; seg < 10; seg++) begin
      rand_inputs();
      run(500);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired after %0d clocks", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule